// File: doc/BRIEF.md
# Selectable ISA Bus Clock Generator

This block produces the clock for an ISA expansion bus. The clock can come from one of two places. The first is a fixed external reference near 7.159 MHz. The second is a divided copy of a fast clock that runs at twice the CPU frequency. A 3-bit select code, loaded through a write strobe, picks the source and the divide ratio. As an example, a 40 MHz CPU gives an 80 MHz fast clock, and the divide-by-10 setting then yields an 8 MHz bus clock.

After reset the block always drives the fixed reference. This lets the system start at any CPU speed. Firmware later measures the CPU frequency and programs a divide ratio.

Changing the selection at run time never produces a runt pulse:
- A new divide ratio takes effect only at the boundary between two output periods.
- A change of source hands over through a two-sided enable handshake. Each enable only moves while its own source clock is low.

Odd divide ratios give a clock whose high time and low time differ by one fast-clock cycle.

Top module: `isaclk_gen`

## Requirements
- R1: While reset is asserted and after it is released, the select code is 000 and the output follows the reference clock, with the reference's period and high time.
- R2: Codes 001, 010, 011 and 100 make the output period 3, 4, 5 and 6 fast-clock cycles respectively.
- R3: Codes 101, 110 and 111 make the output period 8, 10 and 12 fast-clock cycles respectively.
- R4: For a divide ratio N, the output is high for ceil(N/2) fast-clock cycles and low for floor(N/2), so the two phases differ by at most one cycle.
- R5: The select code is captured on a rising fast-clock edge only when the write strobe is 1. A select value presented with the strobe at 0 has no effect on the output.
- R6: A change between two divide ratios takes effect only at a period boundary. Every output period is a whole period of either the old ratio or the new ratio.
- R7: A change of source produces no high pulse shorter than two fast-clock cycles and no low pulse shorter than one. The two sources are never gated onto the output together, and each source's enable changes only while that source clock is low.
- R8: Writing code 000 from any divided setting returns the output to the reference clock's period and high time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_clk | input | 1 | Fast clock at twice the CPU frequency; the divider and select register run on it |
| ref_clk | input | 1 | Fixed reference clock of about 7.159 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_code | input | 3 | Select code: 000 reference, 001..111 divide ratios 3, 4, 5, 6, 8, 10, 12 |
| sel_wr | input | 1 | Write strobe; sel_code is loaded on a fast_clk rising edge while it is 1 |
| bus_clk | output | 1 | Generated ISA bus clock |

## Verification
The bench walks every ordered pair of the eight select codes. After each write it measures the output period and high time once the output has settled. This separates the odd ratios from the even ones and confirms the reference-to-divider handover in both directions. For each pair of two divided ratios, the periods observed right after the write must each match either the old ratio or the new one. This catches any ratio that is applied part-way through a period. A pulse-width monitor that runs throughout the test catches runt pulses at source handovers. A write with the strobe held low must leave the measured period unchanged.

// File: rtl/isaclk_pkg.sv
package isaclk_pkg;

   // Width of the select code and of the divide ratio.
   localparam int CODE_W    = 3;
   localparam int RATIO_W   = 4;
   localparam int RATIO_MIN = 3;
   localparam int RATIO_MAX = 12;

   // Divide ratio for a select code; code 0 (reference) maps to the largest ratio.
   function automatic logic [RATIO_W-1:0] ratio_of(input logic [CODE_W-1:0] code);
      logic [RATIO_W-1:0] r;
      case (code)
         3'd1:    r = RATIO_W'(3);
         3'd2:    r = RATIO_W'(4);
         3'd3:    r = RATIO_W'(5);
         3'd4:    r = RATIO_W'(6);
         3'd5:    r = RATIO_W'(8);
         3'd6:    r = RATIO_W'(10);
         3'd7:    r = RATIO_W'(12);
         default: r = RATIO_W'(RATIO_MAX);
      endcase
      return r;
   endfunction

endpackage

// File: rtl/isaclk_sync.sv
module isaclk_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("isaclk_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= {STAGES{RST_VAL}};
      end else begin
         stage_q <= {stage_q[STAGES-2:0], d};
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/isaclk_divider.sv
module isaclk_divider #(
   parameter int RATIO_W       = 4,
   parameter int RESET_RATIO   = 12,
   parameter bit ODD_HIGH_LONG = 1'b1
) (
   input  logic               fast_clk,
   input  logic               rst_n,
   input  logic [RATIO_W-1:0] ratio_req,
   output logic               div_clk,
   output logic [RATIO_W-1:0] cur_ratio
);

   localparam logic [RATIO_W-1:0] ONE       = RATIO_W'(1);
   localparam logic [RATIO_W-1:0] RST_RATIO = RATIO_W'(RESET_RATIO);

   logic [RATIO_W-1:0] cnt_q;
   logic [RATIO_W-1:0] cnt_nxt;
   logic [RATIO_W-1:0] ratio_nxt;
   logic [RATIO_W-1:0] hi_len;
   logic               wrap;

   // The end of the low phase is the only point where a new ratio is taken.
   assign wrap      = (cnt_q == (cur_ratio - ONE));
   assign cnt_nxt   = wrap ? '0 : (cnt_q + ONE);
   assign ratio_nxt = wrap ? ratio_req : cur_ratio;

   // The variant decides which phase receives the extra cycle of an odd ratio.
   generate
      if (ODD_HIGH_LONG) begin : g_high_long
         assign hi_len = (ratio_nxt + ONE) >> 1;
      end else begin : g_low_long
         assign hi_len = ratio_nxt >> 1;
      end
   endgenerate

   always_ff @(posedge fast_clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         cur_ratio <= RST_RATIO;
         div_clk   <= 1'b1;
      end else begin
         cnt_q     <= cnt_nxt;
         cur_ratio <= ratio_nxt;
         div_clk   <= (cnt_nxt < hi_len);
      end
   end

endmodule

// File: rtl/isaclk_gfmux.sv
module isaclk_gfmux #(
   parameter int SYNC_STAGES = 2
) (
   input  logic ref_clk,
   input  logic div_clk,
   input  logic rst_n,
   input  logic want_div,
   output logic en_ref,
   output logic en_div,
   output logic bus_clk
);

   logic ref_clk_n;
   logic div_clk_n;
   logic ref_d;
   logic div_d;

   // Each enable chain is clocked on the falling edge of its own source.
   assign ref_clk_n = ~ref_clk;
   assign div_clk_n = ~div_clk;

   // A side may turn on only once the other side reports itself off.
   assign ref_d = ~want_div & ~en_div;
   assign div_d =  want_div & ~en_ref;

   isaclk_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) ref_sync_i (
      .clk   (ref_clk_n),
      .rst_n (rst_n),
      .d     (ref_d),
      .q     (en_ref)
   );

   isaclk_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) div_sync_i (
      .clk   (div_clk_n),
      .rst_n (rst_n),
      .d     (div_d),
      .q     (en_div)
   );

   assign bus_clk = (ref_clk & en_ref) | (div_clk & en_div);

endmodule

// File: rtl/isaclk_gen.sv
module isaclk_gen
   import isaclk_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter bit ODD_HIGH_LONG = 1'b1,
   parameter int RESET_RATIO   = 12
) (
   input  logic              fast_clk,
   input  logic              ref_clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] sel_code,
   input  logic              sel_wr,
   output logic              bus_clk
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("isaclk_gen: SYNC_STAGES must be at least 2");
      end
      if ((RESET_RATIO < RATIO_MIN) || (RESET_RATIO > RATIO_MAX)) begin : g_bad_ratio
         $error("isaclk_gen: RESET_RATIO outside the supported range");
      end
      if ((1 << RATIO_W) <= RATIO_MAX) begin : g_bad_width
         $error("isaclk_gen: RATIO_W too narrow for RATIO_MAX");
      end
   endgenerate

   logic [CODE_W-1:0]  code_q;
   logic               want_div;
   logic [RATIO_W-1:0] ratio_req;
   logic [RATIO_W-1:0] cur_ratio;
   logic               div_clk;
   logic               en_ref;
   logic               en_div;

   // Select register; it powers up on the reference code.
   always_ff @(posedge fast_clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
      end else if (sel_wr) begin
         code_q <= sel_code;
      end
   end

   assign want_div  = |code_q;
   // While on the reference, the divider keeps its last ratio.
   assign ratio_req = want_div ? ratio_of(code_q) : cur_ratio;

   isaclk_divider #(
      .RATIO_W       (RATIO_W),
      .RESET_RATIO   (RESET_RATIO),
      .ODD_HIGH_LONG (ODD_HIGH_LONG)
   ) divider_i (
      .fast_clk  (fast_clk),
      .rst_n     (rst_n),
      .ratio_req (ratio_req),
      .div_clk   (div_clk),
      .cur_ratio (cur_ratio)
   );

   isaclk_gfmux #(
      .SYNC_STAGES (SYNC_STAGES)
   ) gfmux_i (
      .ref_clk  (ref_clk),
      .div_clk  (div_clk),
      .rst_n    (rst_n),
      .want_div (want_div),
      .en_ref   (en_ref),
      .en_div   (en_div),
      .bus_clk  (bus_clk)
   );

endmodule

// File: rtl/isaclk_gen_chk.sv
module isaclk_gen_chk
   import isaclk_pkg::*;
(
   input logic               fast_clk,
   input logic               ref_clk,
   input logic               rst_n,
   input logic               sel_wr,
   input logic [CODE_W-1:0]  code_q,
   input logic [RATIO_W-1:0] cur_ratio,
   input logic               div_clk,
   input logic               en_ref,
   input logic               en_div
);

   // R1
   always @(posedge fast_clk) begin
      if (!rst_n) begin
         rst_default_chk: assert ((code_q == '0) && en_ref && !en_div)
            else $error("reset does not select the reference");
      end
   end

   // R5
   sel_hold_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
      !sel_wr |=> $stable(code_q))
      else $error("select changed without a strobe");

   // R6
   ratio_bound_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
      !$stable(cur_ratio) |-> $rose(div_clk))
      else $error("ratio changed away from a period boundary");

   // R7
   src_mutex_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
      $onehot0({en_ref, en_div}))
      else $error("both sources enabled");

   // R7
   div_en_low_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
      !$stable(en_div) |-> !div_clk)
      else $error("divided enable moved while divided clock high");

   // R7
   ref_en_low_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
      !$stable(en_ref) |-> !ref_clk)
      else $error("reference enable moved while reference high");

endmodule

bind isaclk_gen isaclk_gen_chk chk_i (
   .fast_clk  (fast_clk),
   .ref_clk   (ref_clk),
   .rst_n     (rst_n),
   .sel_wr    (sel_wr),
   .code_q    (code_q),
   .cur_ratio (cur_ratio),
   .div_clk   (div_clk),
   .en_ref    (en_ref),
   .en_div    (en_div)
);

// File: tb/isaclk_gen_tb_top.sv
`timescale 1ns/1ps
module isaclk_gen_tb_top;

   localparam real FAST_NS      = 10.0;
   localparam real REF_HALF_NS  = 70.0;
   localparam int  WATCHDOG_CYC = 150000;

   logic       fast_clk = 1'b0;
   logic       ref_clk  = 1'b0;
   logic       rst_n    = 1'b1;
   logic [2:0] sel_code = 3'd0;
   logic       sel_wr   = 1'b0;
   logic       bus_clk;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   bit  mon_en    = 1'b0;
   bit  seen_rise = 1'b0;
   bit  seen_fall = 1'b0;
   real t_rise    = 0.0;
   real t_fall    = 0.0;
   real min_hi    = 1.0e9;
   real min_lo    = 1.0e9;

   isaclk_gen dut_i (
      .fast_clk (fast_clk),
      .ref_clk  (ref_clk),
      .rst_n    (rst_n),
      .sel_code (sel_code),
      .sel_wr   (sel_wr),
      .bus_clk  (bus_clk)
   );

   always #5 fast_clk = ~fast_clk;

   initial begin
      #3;
      forever #(REF_HALF_NS) ref_clk = ~ref_clk;
   end

   // Pulse-width monitor (R7)
   always @(posedge bus_clk) begin
      if (mon_en) begin
         if (seen_fall && (($realtime - t_fall) < min_lo)) min_lo = $realtime - t_fall;
         t_rise    = $realtime;
         seen_rise = 1'b1;
      end
   end

   always @(negedge bus_clk) begin
      if (mon_en) begin
         if (seen_rise && (($realtime - t_rise) < min_hi)) min_hi = $realtime - t_rise;
         t_fall    = $realtime;
         seen_fall = 1'b1;
      end
   end

   function automatic int exp_ratio(input int code);
      if (code <= 4) return code + 2;
      return 2 * (code - 5) + 8;
   endfunction

   function automatic real exp_per(input int code);
      if (code == 0) return 2.0 * REF_HALF_NS;
      return exp_ratio(code) * FAST_NS;
   endfunction

   function automatic real exp_hi(input int code);
      if (code == 0) return REF_HALF_NS;
      return ((exp_ratio(code) + 1) / 2) * FAST_NS;
   endfunction

   function automatic bit near(input real a, input real b);
      return ((a - b) < 0.5) && ((b - a) < 0.5);
   endfunction

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic check(input bit ok, input string tag, input string what,
                        input real act, input real expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0.2f expected %0.2f", tag, what, act, expv);
      end
   endtask

   task automatic measure(output real per, output real hi);
      real t0, t1, t2;
      @(posedge bus_clk); t0 = $realtime;
      @(negedge bus_clk); t1 = $realtime;
      @(posedge bus_clk); t2 = $realtime;
      per = t2 - t0;
      hi  = t1 - t0;
   endtask

   task automatic write_code(input int c, input bit we);
      @(negedge fast_clk);
      sel_code = 3'(c);
      sel_wr   = we;
      @(negedge fast_clk);
      sel_wr   = 1'b0;
   endtask

   task automatic verify_steady(input int code, input string ref_tag);
      real   per, hi;
      string ptag, htag;
      #2500;
      ptag = (code == 0) ? ref_tag : ((code <= 4) ? "R2" : "R3");
      htag = (code == 0) ? ref_tag : "R4";
      repeat (2) begin
         measure(per, hi);
         check(near(per, exp_per(code)), ptag, "period", per, exp_per(code));
         check(near(hi, exp_hi(code)), htag, "high time", hi, exp_hi(code));
      end
   endtask

   // R6: every period right after a ratio write is whole, old or new
   task automatic verify_handover(input int ca, input int cb);
      real per, hi;
      bit  ok;
      repeat (3) begin
         measure(per, hi);
         ok = (near(per, exp_per(ca)) && near(hi, exp_hi(ca))) ||
              (near(per, exp_per(cb)) && near(hi, exp_hi(cb)));
         check(ok, "R6", "period across ratio change", per, exp_per(cb));
      end
   endtask

   initial begin
      repeat (WATCHDOG_CYC) @(posedge fast_clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog (all requirements): actual %0d cycles expected completion earlier",
                  WATCHDOG_CYC);
         report();
         $finish;
      end
   end

   initial begin
      bit  rst_ok;
      real per, hi;
      #1 rst_n = 1'b0;

      // R1: during reset the output follows the reference
      rst_ok = 1'b1;
      repeat (12) begin
         #23;
         if (bus_clk !== ref_clk) rst_ok = 1'b0;
      end
      check(rst_ok, "R1", "output equals reference in reset", real'(bus_clk), real'(ref_clk));

      @(negedge fast_clk);
      rst_n  = 1'b1;
      mon_en = 1'b1;

      // R1: default selection after release, no write yet
      verify_steady(0, "R1");

      // R2 R3 R4 R6 R8: every ordered pair of codes
      for (int a = 0; a < 8; a++) begin
         for (int b = 0; b < 8; b++) begin
            write_code(a, 1'b1);
            verify_steady(a, "R8");
            write_code(b, 1'b1);
            if ((a != 0) && (b != 0)) verify_handover(a, b);
            verify_steady(b, "R8");
         end
      end

      // R5: a select value without the strobe is ignored
      write_code(5, 1'b1);
      verify_steady(5, "R8");
      write_code(2, 1'b0);
      sel_code = 3'd2;
      #2500;
      measure(per, hi);
      check(near(per, exp_per(5)), "R5", "period after unstrobed select", per, exp_per(5));
      write_code(0, 1'b0);
      #2500;
      measure(per, hi);
      check(near(per, exp_per(5)), "R5", "period after unstrobed zero", per, exp_per(5));

      // R7: no runt pulse anywhere in the run
      check(min_hi > (2.0 * FAST_NS - 0.5), "R7", "shortest high pulse", min_hi, 2.0 * FAST_NS);
      check(min_lo > (FAST_NS - 0.5), "R7", "shortest low pulse", min_lo, FAST_NS);

      done = 1'b1;
      report();
      $finish;
   end

endmodule